// File: doc/BRIEF.md
# Serial-Clocked Memory Write Front End

This block is the slave side of a four-wire serial link that loads bytes into an 8K x 8 on-chip register-file array. The host pulls the active-low select low and clocks in bits on the data-in line. It sends an 8-bit command first, then a 16-bit address. After that it sends as many data bytes as it likes. Every bit travels most significant bit first. Only the write command (value 02h) is acted on. Each complete data byte produces one write strobe on a synchronous memory port. After each byte, an internal pointer moves to the next location.

All serial inputs are oversampled by the block's own system clock through synchronizer stages, so the block runs entirely in the system clock domain. A mode input picks how the pointer steps:
- In page mode it cycles inside a 32-byte page.
- In burst mode it walks the whole 13-bit space and wraps from the top back to zero.

A write lasts until the select line returns high. The serial data output is never driven.

Top module: `spi_sram_wr_slave`

## Requirements
- R1: While cs_n is high, no SCK edge is accepted, no write strobe is raised, and the command/address/data progress and any partial byte are cleared, so the next transaction starts afresh from the command phase.
- R2: The first 8 bits after cs_n falls, sampled on SCK rising edges MSB first, form the command; only the value 8'h02 starts a write.
- R3: After the write command, 16 address bits follow MSB first; the top 3 are ignored and the low 13 set the pointer (0000h to 1FFFh).
- R4: Each complete 8-bit data byte (MSB first) raises mem_we for exactly one clk cycle, with mem_addr equal to the current pointer and mem_wdata equal to the byte; the first byte goes to the start address.
- R5: With burst_mode = 0 the pointer adds one to its low 5 bits only, wrapping from offset 31 to offset 0, and keeps its upper 8 bits.
- R6: With burst_mode = 1 the pointer adds one across all 13 bits, wrapping from 1FFFh to 0000h.
- R7: Data bytes keep being written for as long as cs_n stays low; when cs_n rises partway through a byte, that partial byte is discarded and no write occurs for it.
- R8: Any command other than 8'h02 leaves the block ignoring SI until cs_n rises, with no write strobe in that time.
- R9: SO stays high-impedance at all times.
- R10: An SCK rising edge that reaches the sampling stage in the same clk cycle as the release of cs_n is not accepted, so a byte whose last bit coincides with the release is not written.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock that oversamples the serial lines |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously |
| sck | input | 1 | Serial clock from host, idle low, data taken on rising edge |
| cs_n | input | 1 | Active-low transaction select |
| si | input | 1 | Serial data in, MSB first |
| so | output | 1 | Serial data out, always high-impedance |
| burst_mode | input | 1 | Pointer sequencing: 0 page wrap, 1 whole-array wrap |
| mem_we | output | 1 | One-cycle write strobe to the array |
| mem_addr | output | 13 | Array byte address for the write |
| mem_wdata | output | 8 | Byte to store |

## Verification
Releasing the select line and capturing the final bit of a data byte can fall in the same clk cycle, because both lines pass through synchronizers of equal depth. The bench provokes this by raising cs_n at the same instant as the eighth SCK rising edge of the last byte. It then judges the outcome by the write sequence: every earlier byte must land at its pointer, and the clipped byte must produce no strobe at all. A second coincidence is checked too: a write at page offset 31 or at address 1FFFh occurs in the same cycle as the pointer wrap, and the bench checks that the next byte lands at the wrapped address.

// File: rtl/spi_sram_wr_pkg.sv
package spi_sram_wr_pkg;

  localparam int CMD_BITS = 8;
  localparam int ADR_FRAME_BITS = 16;
  localparam logic [CMD_BITS-1:0] OP_WRITE = 8'h02;

  typedef enum logic [1:0] {
    PH_CMD = 2'd0,
    PH_ADR = 2'd1,
    PH_DAT = 2'd2,
    PH_IGN = 2'd3
  } phase_t;

endpackage

// File: rtl/spi_wr_sync.sv
module spi_wr_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_sn,
  input  logic sck,
  input  logic cs_n,
  input  logic si,
  output logic bit_stb,
  output logic sel_act,
  output logic bit_val
);

  localparam int LINES = 3;
  localparam logic [LINES-1:0] IDLE_V = 3'b010;

  logic [LINES-1:0] raw;
  logic [STAGES-1:0][LINES-1:0] stg_q;
  logic [STAGES-1:0][LINES-1:0] stg_d;
  logic [LINES-1:0] tap;
  logic sck_prev_q;

  assign raw = {sck, cs_n, si};

  generate
    if (STAGES > 1) begin : g_chain
      assign stg_d = {stg_q[STAGES-2:0], raw};
    end else begin : g_single
      assign stg_d = raw;
    end
  endgenerate

  always_ff @(posedge clk or negedge rst_sn) begin
    if (!rst_sn) begin
      stg_q      <= {STAGES{IDLE_V}};
      sck_prev_q <= 1'b0;
    end else begin
      stg_q      <= stg_d;
      sck_prev_q <= tap[2];
    end
  end

  assign tap     = stg_q[STAGES-1];
  assign bit_stb = tap[2] & ~sck_prev_q;
  assign sel_act = ~tap[1];
  assign bit_val = tap[0];

endmodule

// File: rtl/spi_wr_frame.sv
module spi_wr_frame
  import spi_sram_wr_pkg::*;
#(
  parameter int ADDR_W = 13,
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_sn,
  input  logic              bit_stb,
  input  logic              sel_act,
  input  logic              bit_val,
  output logic              adr_ld,
  output logic [ADDR_W-1:0] adr_val,
  output logic              byte_stb,
  output logic [DATA_W-1:0] byte_val
);

  localparam int CNT_W = $clog2(ADR_FRAME_BITS);
  localparam logic [CNT_W-1:0] CMD_LAST = CNT_W'(CMD_BITS - 1);
  localparam logic [CNT_W-1:0] ADR_LAST = CNT_W'(ADR_FRAME_BITS - 1);
  localparam logic [CNT_W-1:0] DAT_LAST = CNT_W'(DATA_W - 1);

  phase_t ph_q, ph_d;
  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic [ADR_FRAME_BITS-1:0] sh_q, sh_d, sh_in;
  logic ald_q, ald_d, bst_q, bst_d;
  logic take, at_last;

  always_comb begin
    take  = bit_stb & sel_act;
    sh_in = {sh_q[ADR_FRAME_BITS-2:0], bit_val};
    case (ph_q)
      PH_CMD:  at_last = (cnt_q == CMD_LAST);
      PH_ADR:  at_last = (cnt_q == ADR_LAST);
      default: at_last = (cnt_q == DAT_LAST);
    endcase
    ph_d  = ph_q;
    cnt_d = cnt_q;
    sh_d  = sh_q;
    ald_d = 1'b0;
    bst_d = 1'b0;
    if (!sel_act) begin
      ph_d  = PH_CMD;
      cnt_d = '0;
      sh_d  = '0;
    end else if (take && ph_q != PH_IGN) begin
      sh_d  = sh_in;
      cnt_d = at_last ? '0 : cnt_q + 1'b1;
      if (at_last) begin
        case (ph_q)
          PH_CMD: ph_d = (sh_in[CMD_BITS-1:0] == OP_WRITE) ? PH_ADR : PH_IGN;
          PH_ADR: begin
            ph_d  = PH_DAT;
            ald_d = 1'b1;
          end
          PH_DAT: bst_d = 1'b1;
          default: ;
        endcase
      end
    end
  end

  always_ff @(posedge clk or negedge rst_sn) begin
    if (!rst_sn) begin
      ph_q  <= PH_CMD;
      cnt_q <= '0;
      sh_q  <= '0;
      ald_q <= 1'b0;
      bst_q <= 1'b0;
    end else begin
      ph_q  <= ph_d;
      cnt_q <= cnt_d;
      sh_q  <= sh_d;
      ald_q <= ald_d;
      bst_q <= bst_d;
    end
  end

  assign adr_ld   = ald_q;
  assign adr_val  = sh_q[ADDR_W-1:0];
  assign byte_stb = bst_q;
  assign byte_val = sh_q[DATA_W-1:0];

  assert_idle_clear_R1: assert property (@(posedge clk) disable iff (!rst_sn)
    !sel_act |=> (ph_q == PH_CMD && cnt_q == '0 && sh_q == '0));

  assert_release_drop_R10: assert property (@(posedge clk) disable iff (!rst_sn)
    !sel_act |=> (!bst_q && !ald_q));

  assert_ignore_quiet_R8: assert property (@(posedge clk) disable iff (!rst_sn)
    (ph_q == PH_IGN) |=> (!bst_q && !ald_q));

endmodule

// File: rtl/spi_wr_ptr.sv
module spi_wr_ptr #(
  parameter int ADDR_W = 13,
  parameter int PAGE_W = 5
) (
  input  logic              clk,
  input  logic              rst_sn,
  input  logic              ld,
  input  logic [ADDR_W-1:0] ld_adr,
  input  logic              adv,
  input  logic              burst,
  output logic [ADDR_W-1:0] ptr
);

  localparam int HI_W = ADDR_W - PAGE_W;

  logic [ADDR_W-1:0] ptr_q, ptr_d, page_nx, flat_nx;
  logic [PAGE_W-1:0] off_nx;

  always_comb begin
    off_nx  = ptr_q[PAGE_W-1:0] + 1'b1;
    page_nx = {ptr_q[ADDR_W-1:PAGE_W], off_nx};
    flat_nx = ptr_q + 1'b1;
    ptr_d   = ptr_q;
    if (ld) begin
      ptr_d = ld_adr;
    end else if (adv) begin
      ptr_d = burst ? flat_nx : page_nx;
    end
  end

  always_ff @(posedge clk or negedge rst_sn) begin
    if (!rst_sn) begin
      ptr_q <= '0;
    end else begin
      ptr_q <= ptr_d;
    end
  end

  assign ptr = ptr_q;

  assert_page_keep_R5: assert property (@(posedge clk) disable iff (!rst_sn)
    (adv && !burst && !ld) |=> (ptr_q[ADDR_W-1:PAGE_W] == $past(ptr_q[ADDR_W-1:PAGE_W])));

  assert_page_wrap_R5: assert property (@(posedge clk) disable iff (!rst_sn)
    (adv && !burst && !ld && (&ptr_q[PAGE_W-1:0])) |=> (ptr_q[PAGE_W-1:0] == '0));

  assert_array_wrap_R6: assert property (@(posedge clk) disable iff (!rst_sn)
    (adv && burst && !ld && (&ptr_q)) |=> (ptr_q == '0));

  assert_load_R3: assert property (@(posedge clk) disable iff (!rst_sn)
    ld |=> (ptr_q == $past(ld_adr)));

  initial begin
    assert (HI_W > 0) else $error("page width must be below address width");
  end

endmodule

// File: rtl/spi_sram_wr_slave.sv
module spi_sram_wr_slave #(
  parameter int ADDR_W = 13,
  parameter int DATA_W = 8,
  parameter int PAGE_W = 5,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              sck,
  input  logic              cs_n,
  input  logic              si,
  output wire               so,
  input  logic              burst_mode,
  output logic              mem_we,
  output logic [ADDR_W-1:0] mem_addr,
  output logic [DATA_W-1:0] mem_wdata
);

  logic [1:0] rst_pipe_q;
  logic rst_sn;
  logic bit_stb, sel_act, bit_val;
  logic adr_ld, byte_stb;
  logic [ADDR_W-1:0] adr_val, ptr;
  logic [DATA_W-1:0] byte_val;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_pipe_q <= 2'b00;
    end else begin
      rst_pipe_q <= {rst_pipe_q[0], 1'b1};
    end
  end
  assign rst_sn = rst_pipe_q[1];

  spi_wr_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk     (clk),
    .rst_sn  (rst_sn),
    .sck     (sck),
    .cs_n    (cs_n),
    .si      (si),
    .bit_stb (bit_stb),
    .sel_act (sel_act),
    .bit_val (bit_val)
  );

  spi_wr_frame #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_frame (
    .clk      (clk),
    .rst_sn   (rst_sn),
    .bit_stb  (bit_stb),
    .sel_act  (sel_act),
    .bit_val  (bit_val),
    .adr_ld   (adr_ld),
    .adr_val  (adr_val),
    .byte_stb (byte_stb),
    .byte_val (byte_val)
  );

  spi_wr_ptr #(.ADDR_W(ADDR_W), .PAGE_W(PAGE_W)) u_ptr (
    .clk    (clk),
    .rst_sn (rst_sn),
    .ld     (adr_ld),
    .ld_adr (adr_val),
    .adv    (byte_stb),
    .burst  (burst_mode),
    .ptr    (ptr)
  );

  assign mem_we    = byte_stb;
  assign mem_addr  = ptr;
  assign mem_wdata = byte_val;
  assign so        = 1'bz;

  assert_single_strobe_R4: assert property (@(posedge clk) disable iff (!rst_sn)
    mem_we |=> !mem_we);

  assert_no_load_on_write_R4: assert property (@(posedge clk) disable iff (!rst_sn)
    !(adr_ld && byte_stb));

endmodule

// File: tb/sim_spi_sram_wr_slave.sv
module sim_spi_sram_wr_slave;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic sck = 1'b0;
  logic cs_n = 1'b1;
  logic si = 1'b0;
  logic burst_mode = 1'b0;
  wire  so;
  logic mem_we;
  logic [12:0] mem_addr;
  logic [7:0] mem_wdata;

  int n_chk = 0;
  int n_fail = 0;
  bit finished = 0;
  bit so_bad = 0;
  int got_a[$];
  int got_d[$];
  int exp_a[$];
  int exp_d[$];

  always #2 clk = ~clk;

  spi_sram_wr_slave u0 (
    .clk(clk), .rst_n(rst_n), .sck(sck), .cs_n(cs_n), .si(si), .so(so),
    .burst_mode(burst_mode), .mem_we(mem_we), .mem_addr(mem_addr), .mem_wdata(mem_wdata)
  );

  always @(negedge clk) begin
    if (mem_we === 1'b1) begin
      got_a.push_back(int'(mem_addr));
      got_d.push_back(int'(mem_wdata));
    end
    if (so !== 1'bz) so_bad = 1;
  end

  task automatic check(input bit ok, input string req, input string what, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  function automatic int next_ptr(input int p, input bit brst);
    if (brst) return (p + 1) & 32'h1FFF;
    return (p & 32'h1FE0) | ((p + 1) & 32'h1F);
  endfunction

  task automatic put_bit(input logic b);
    @(negedge clk);
    si = b;
    sck = 1'b0;
    repeat (4) @(negedge clk);
    sck = 1'b1;
    repeat (4) @(negedge clk);
  endtask

  task automatic put_byte(input logic [7:0] v);
    for (int i = 7; i >= 0; i--) put_bit(v[i]);
  endtask

  task automatic sel_on();
    @(negedge clk);
    sck = 1'b0;
    cs_n = 1'b0;
    repeat (4) @(negedge clk);
  endtask

  task automatic sel_off();
    @(negedge clk);
    sck = 1'b0;
    repeat (2) @(negedge clk);
    cs_n = 1'b1;
    repeat (10) @(negedge clk);
  endtask

  task automatic compare(input string req);
    check(got_a.size() == exp_a.size(), req, "write count", got_a.size(), exp_a.size());
    if (got_a.size() == exp_a.size()) begin
      foreach (exp_a[i]) begin
        check(got_a[i] == exp_a[i], req, "write address", got_a[i], exp_a[i]);
        check(got_d[i] == exp_d[i], req, "write data", got_d[i], exp_d[i]);
      end
    end
  endtask

  task automatic run_txn(input string req, input logic [7:0] op, input logic [15:0] a16,
                         input int nb, input bit brst, input int tail, input bit clip);
    int p;
    logic [7:0] d;
    burst_mode = brst;
    got_a.delete(); got_d.delete(); exp_a.delete(); exp_d.delete();
    sel_on();
    put_byte(op);
    for (int i = 15; i >= 0; i--) put_bit(a16[i]);
    p = int'(a16[12:0]);
    for (int k = 0; k < nb; k++) begin
      d = 8'($urandom);
      if (clip && k == nb - 1) begin
        for (int i = 7; i >= 1; i--) put_bit(d[i]);
        @(negedge clk);
        si = d[0];
        sck = 1'b0;
        repeat (4) @(negedge clk);
        sck = 1'b1;
        cs_n = 1'b1;
        repeat (6) @(negedge clk);
        sck = 1'b0;
        repeat (8) @(negedge clk);
      end else begin
        put_byte(d);
        if (op == 8'h02) begin
          exp_a.push_back(p);
          exp_d.push_back(int'(d));
          p = next_ptr(p, brst);
        end
      end
    end
    for (int t = 0; t < tail; t++) put_bit(1'($urandom));
    if (!clip) sel_off();
    compare(req);
  endtask

  task automatic finish_run();
    finished = 1;
    $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
    $finish;
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    if (!finished) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog expired before completion");
      finish_run();
    end
  end

  initial begin
    void'($urandom(32'h5EED_0021));
    repeat (5) @(negedge clk);
    rst_n = 1'b1;
    repeat (5) @(negedge clk);

    // R9 / reset state
    check(mem_we === 1'b0, "R9", "mem_we after reset", int'(mem_we), 0);
    check(so === 1'bz, "R9", "so driven after reset", int'(so === 1'bz), 1);

    // R1: clocking with select high produces nothing
    got_a.delete(); got_d.delete(); exp_a.delete(); exp_d.delete();
    put_byte(8'h02);
    for (int i = 0; i < 40; i++) put_bit(1'($urandom));
    @(negedge clk); sck = 1'b0; repeat (6) @(negedge clk);
    compare("R1");

    // R1: aborted address phase must not leak into the next transaction
    sel_on();
    put_byte(8'h02);
    for (int i = 0; i < 5; i++) put_bit(1'b1);
    sel_off();
    run_txn("R1", 8'h02, 16'h0123, 3, 1'b0, 0, 1'b0);

    // R2 / R4: plain write
    run_txn("R4", 8'h02, 16'h0456, 4, 1'b1, 0, 1'b0);

    // R3: upper three address bits ignored
    run_txn("R3", 8'h02, 16'hEABC, 2, 1'b1, 0, 1'b0);

    // R5: page loop from offset 28 over 40 bytes
    run_txn("R5", 8'h02, 16'h0A5C, 40, 1'b0, 0, 1'b0);

    // R5: page wrap at top of array stays in last page
    run_txn("R5", 8'h02, 16'h1FFF, 2, 1'b0, 0, 1'b0);

    // R6: burst wrap 1FFF -> 0000
    run_txn("R6", 8'h02, 16'h1FFD, 5, 1'b1, 0, 1'b0);

    // R7: partial trailing byte discarded
    run_txn("R7", 8'h02, 16'h0300, 4, 1'b1, 5, 1'b0);

    // R8: unknown commands ignored
    run_txn("R8", 8'h03, 16'h0100, 3, 1'b1, 0, 1'b0);
    run_txn("R8", 8'h82, 16'h0100, 3, 1'b0, 0, 1'b0);

    // R2: command immediately after an ignored one still works
    run_txn("R2", 8'h02, 16'h0100, 2, 1'b0, 0, 1'b0);

    // R10: release coinciding with the last bit edge
    run_txn("R10", 8'h02, 16'h0777, 3, 1'b1, 0, 1'b1);
    run_txn("R10", 8'h02, 16'h001E, 2, 1'b0, 0, 1'b1);

    // random mix (R4, R5, R6, R7, R8)
    for (int n = 0; n < 25; n++) begin
      logic [7:0] op;
      op = (($urandom % 5) == 0) ? 8'($urandom | 32'h10) : 8'h02;
      run_txn("R4", op, 16'($urandom), 1 + int'($urandom % 12), 1'($urandom),
              int'($urandom % 8), 1'b0);
    end

    check(!so_bad, "R9", "so left high-impedance", int'(so_bad), 0);
    finish_run();
  end

endmodule